// File: doc/BRIEF.md
# Two-Wire Bus Target with General-Call and Speed-Mode Tracking

This block is the protocol engine of a two-wire (I2C) target. It samples the raw clock and data lines on a fast system clock and drives the data line only through an open-drain pull-down enable. It finds START, repeated START and STOP conditions. It decodes the first byte of each transfer, and it moves data bytes to a simple register interface. In the write direction it gives a one-cycle strobe with the received byte. In the read direction it gives a one-cycle load request and samples the byte that goes out.

Besides its own seven-bit address, the engine answers the general-call address. There it accepts only two command codes, and one of them raises a one-cycle reset request for the surrounding device. It also recognises the high-speed master code, which it must leave unacknowledged, and it keeps a flag that says the bus is in high-speed mode until the next STOP.

Top module: `i2c_target_gc`

## Requirements
- R1: After reset, `sda_oe` is 0 and `hs_mode` is 0. No `rx_valid`, `tx_req` or `gc_reset_req` pulse appears while the bus is idle.
- R2: A first byte whose upper seven bits equal `OWN_ADDR` is acknowledged, and bit 0 of that byte selects read (1) or write (0). A first byte naming another address is not acknowledged, and the block ignores the rest of that transfer (no ACK, no `rx_valid`).
- R3: In a write to the own address, every data byte arrives MSB first and is acknowledged. Each byte is presented once on `rx_data` with a single-cycle `rx_valid`.
- R4: In a read, the block asserts `tx_req` for one cycle and shifts out `tx_data` MSB first. A master ACK (data low on the ninth clock) loads the next byte. A master NACK makes the block release the data line and stay silent until STOP or repeated START.
- R5: A first byte of exactly 0x00 (general call) is always acknowledged. The byte 0x01 is not acknowledged.
- R6: After a general call, only the data bytes 0x04 and 0x06 are acknowledged. Any other byte is not acknowledged, and later bytes of that transfer are ignored.
- R7: The general-call data byte 0x06 raises `gc_reset_req` for exactly one cycle. The byte 0x04 raises no request.
- R8: A first byte of the form 00001xxx (the high-speed master code, with no read/write bit) is never acknowledged, and it sets `hs_mode`.
- R9: `hs_mode` stays set across repeated STARTs and clears at the next STOP.
- R10: A falling data edge while the clock is high is START, and a rising data edge while the clock is high is STOP. A repeated START restarts address decoding, and STOP releases the data line.
- R11: The block changes its data-line drive only while the clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the fastest bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line (wired level) |
| sda_oe | output | 1 | 1 pulls the data line low |
| rx_valid | output | 1 | One-cycle strobe: a write byte is on `rx_data` |
| rx_data | output | 8 | Last byte written by the master |
| tx_req | output | 1 | One-cycle strobe: `tx_data` is sampled in this cycle |
| tx_data | input | 8 | Byte to send in a read |
| gc_reset_req | output | 1 | One-cycle general-call reset request |
| hs_mode | output | 1 | High-speed mode is active |

## Verification
The first byte is driven with the own address in both directions, with a foreign address, with 0x00, with 0x01 and with a master code. The ACK bit seen on the bus shows whether each of these classes was decoded correctly. General-call data is tried with 0x04, 0x06, an unsupported code, and 0x06 sent after a rejected code. This shows that acknowledging, requesting a reset and ignoring the rest are separate decisions. Reads end once with a master ACK and once with a NACK, followed by one more clocked byte, so that continuing to transmit can be told apart from releasing the line. A repeated START after the master code shows that the mode flag persists while address decoding restarts.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TXACK, ST_WAIT
  } eng_state_t;

  typedef enum logic [1:0] {
    PH_ADDR, PH_WRITE, PH_GCALL
  } rx_phase_t;

  localparam logic [7:0] GC_ADDR_BYTE = 8'h00;
  localparam logic [7:0] GC_CMD_RESET = 8'h06;
  localparam logic [7:0] GC_CMD_LATCH = 8'h04;

  function automatic logic is_master_code(input logic [7:0] b);
    return b[7:3] == 5'b00001;
  endfunction

  function automatic logic gc_code_accepted(input logic [7:0] b);
    return (b == GC_CMD_RESET) || (b == GC_CMD_LATCH);
  endfunction

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2ct_linecond.sv
module i2ct_linecond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [1:0] synced;
  logic       scl_q, sda_q;

  i2ct_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_raw, sda_raw}), .q(synced)
  );

  assign scl_s = synced[1];
  assign sda_s = synced[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

  // R10
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !stop_evt);
endmodule

// File: rtl/i2c_target_gc.sv
module i2c_target_gc
  import i2ct_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR    = 7'h48,
  parameter int         SYNC_STAGES = 2,
  parameter int         BYTE_BITS   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_in,
  input  logic                 sda_in,
  output logic                 sda_oe,
  output logic                 rx_valid,
  output logic [BYTE_BITS-1:0] rx_data,
  output logic                 tx_req,
  input  logic [BYTE_BITS-1:0] tx_data,
  output logic                 gc_reset_req,
  output logic                 hs_mode
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  i2ct_linecond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  eng_state_t           state;
  rx_phase_t            phase;
  logic [CNT_W-1:0]     bit_cnt;
  logic [BYTE_BITS-1:0] shreg;
  logic                 rd_dir, m_ack;

  // named decode events
  logic byte_done, own_hit, gc_hit, mcode_hit;
  assign byte_done = (state == ST_RX) && scl_fall && (bit_cnt == FULL);
  assign own_hit   = shreg[BYTE_BITS-1:1] == OWN_ADDR;
  assign gc_hit    = shreg == GC_ADDR_BYTE;
  assign mcode_hit = is_master_code(shreg);

  assign tx_req = scl_fall &&
                  (((state == ST_ACK) && rd_dir) || ((state == ST_TXACK) && m_ack));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  phase <= PH_ADDR;  bit_cnt <= '0;  shreg <= '0;
      sda_oe <= 1'b0;    hs_mode <= 1'b0;   rd_dir <= 1'b0; m_ack <= 1'b0;
      rx_valid <= 1'b0;  rx_data <= '0;     gc_reset_req <= 1'b0;
    end else begin
      rx_valid     <= 1'b0;
      gc_reset_req <= 1'b0;
      if (stop_evt) begin
        state <= ST_IDLE;  sda_oe <= 1'b0;  hs_mode <= 1'b0;
      end else if (start_evt) begin
        state <= ST_RX;  phase <= PH_ADDR;  bit_cnt <= '0;
        sda_oe <= 1'b0;  rd_dir <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && bit_cnt != FULL) begin
              shreg   <= {shreg[BYTE_BITS-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_done) begin
              bit_cnt <= '0;
              state   <= ST_WAIT;
              unique case (phase)
                PH_ADDR: begin
                  if (own_hit) begin
                    sda_oe <= 1'b1;  state <= ST_ACK;
                    rd_dir <= shreg[0];  phase <= PH_WRITE;
                  end else if (gc_hit) begin
                    sda_oe <= 1'b1;  state <= ST_ACK;  phase <= PH_GCALL;
                  end else if (mcode_hit) begin
                    hs_mode <= 1'b1;
                  end
                end
                PH_WRITE: begin
                  sda_oe <= 1'b1;  state <= ST_ACK;
                  rx_valid <= 1'b1;  rx_data <= shreg;
                end
                default: begin
                  if (gc_code_accepted(shreg)) begin
                    sda_oe <= 1'b1;  state <= ST_ACK;
                    gc_reset_req <= (shreg == GC_CMD_RESET);
                  end
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rd_dir) begin
                shreg  <= tx_data;
                sda_oe <= ~tx_data[BYTE_BITS-1];
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              if (bit_cnt == FULL) begin
                sda_oe <= 1'b0;  state <= ST_TXACK;
              end else begin
                sda_oe <= ~shreg[BYTE_BITS-2];
                shreg  <= {shreg[BYTE_BITS-2:0], 1'b0};
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
            end else if (scl_fall) begin
              bit_cnt <= '0;
              if (m_ack) begin
                shreg  <= tx_data;
                sda_oe <= ~tx_data[BYTE_BITS-1];
                state  <= ST_TX;
              end else begin
                state  <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11
  oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));
  // R7
  gc_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reset_req |=> !gc_reset_req);
  // R8
  mcode_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_mode) |-> !sda_oe);
  // R9
  hs_clear_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !hs_mode);
  // R3
  rx_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> sda_oe);
  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);
endmodule

// File: tb/tb_i2c_target_gc.sv
module tb_i2c_target_gc;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, rx_valid, tx_req, gc_reset_req, hs_mode;
  logic [7:0] rx_data, tx_data;
  wire  sda_bus = sda_m & ~sda_oe;

  int n_chk = 0, n_bad = 0;
  int rx_cnt = 0, gc_cnt = 0, txr_cnt = 0, oe_viol = 0;
  logic [7:0] rx_last = 8'h00;
  logic oe_prev = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_target_gc dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .sda_oe(sda_oe),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_req(tx_req), .tx_data(tx_data),
    .gc_reset_req(gc_reset_req), .hs_mode(hs_mode)
  );

  function automatic logic [7:0] pat(int k);
    return 8'hC3 + 8'(k * 41);
  endfunction
  assign tx_data = pat(txr_cnt);

  always @(posedge clk) begin
    if (rx_valid) begin rx_cnt <= rx_cnt + 1; rx_last <= rx_data; end
    if (gc_reset_req) gc_cnt <= gc_cnt + 1;
    if (tx_req) txr_cnt <= txr_cnt + 1;
    if (rst_n && sda_oe != oe_prev && scl) oe_viol <= oe_viol + 1;
    oe_prev <= sda_oe;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    sda_m = b; tick(Q);
    scl = 1'b1; tick(Q);
    r = sda_bus; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, r); b[i] = r; end
    clk_bit(~give_ack, r);
  endtask

  task automatic t_reset();
    check("R1 sda_oe", 32'(sda_oe), 0);
    check("R1 hs_mode", 32'(hs_mode), 0);
    tick(20);
    check("R1 no pulses", 32'(rx_cnt + gc_cnt + txr_cnt), 0);
  endtask

  task automatic t_write();
    logic a; int c0 = rx_cnt;
    bus_start();
    wr_byte(8'h90, a); check("R2 own addr write ack", 32'(a), 1);
    wr_byte(8'hA5, a); check("R3 data ack", 32'(a), 1);
    check("R3 rx_data first", 32'(rx_last), 32'hA5);
    wr_byte(8'h3C, a); check("R3 data ack 2", 32'(a), 1);
    check("R3 rx count", 32'(rx_cnt - c0), 2);
    check("R3 rx_data second", 32'(rx_last), 32'h3C);
    bus_stop();
    check("R10 released after stop", 32'(sda_oe), 0);
  endtask

  task automatic t_foreign();
    logic a; int c0 = rx_cnt;
    bus_start();
    wr_byte(8'h92, a); check("R2 foreign addr nack", 32'(a), 0);
    wr_byte(8'h55, a); check("R2 foreign data nack", 32'(a), 0);
    check("R2 no rx strobe", 32'(rx_cnt - c0), 0);
    bus_stop();
  endtask

  task automatic t_read();
    logic a; logic [7:0] b; int k0 = txr_cnt;
    bus_start();
    wr_byte(8'h91, a); check("R2 own addr read ack", 32'(a), 1);
    rd_byte(1'b1, b);  check("R4 first byte", 32'(b), 32'(pat(k0)));
    rd_byte(1'b0, b);  check("R4 second byte", 32'(b), 32'(pat(k0 + 1)));
    rd_byte(1'b0, b);  check("R4 released after nack", 32'(b), 32'hFF);
    check("R4 tx_req count", 32'(txr_cnt - k0), 2);
    bus_stop();
  endtask

  task automatic t_gcall();
    logic a; int g0 = gc_cnt;
    bus_start();
    wr_byte(8'h00, a); check("R5 gc addr ack", 32'(a), 1);
    wr_byte(8'h04, a); check("R6 code 04 ack", 32'(a), 1);
    check("R7 no request on 04", 32'(gc_cnt - g0), 0);
    wr_byte(8'h06, a); check("R6 code 06 ack", 32'(a), 1);
    check("R7 one request on 06", 32'(gc_cnt - g0), 1);
    bus_stop();
    bus_start();
    wr_byte(8'h00, a); check("R5 gc addr ack again", 32'(a), 1);
    wr_byte(8'h07, a); check("R6 code 07 nack", 32'(a), 0);
    wr_byte(8'h06, a); check("R6 ignored after nack", 32'(a), 0);
    check("R6 no request after nack", 32'(gc_cnt - g0), 1);
    bus_stop();
    bus_start();
    wr_byte(8'h01, a); check("R5 byte 01 nack", 32'(a), 0);
    bus_stop();
  endtask

  task automatic t_hs();
    logic a;
    bus_start();
    wr_byte(8'h0D, a); check("R8 master code nack", 32'(a), 0);
    check("R8 hs_mode set", 32'(hs_mode), 1);
    bus_rstart();
    check("R9 hs kept over rstart", 32'(hs_mode), 1);
    wr_byte(8'h90, a); check("R10 addr after rstart ack", 32'(a), 1);
    wr_byte(8'h77, a); check("R3 data in hs", 32'(rx_last), 32'h77);
    check("R9 hs still set", 32'(hs_mode), 1);
    bus_stop();
    check("R9 hs cleared by stop", 32'(hs_mode), 0);
  endtask

  task automatic t_rstart_mid();
    logic a; logic [7:0] b; int k0;
    bus_start();
    wr_byte(8'h90, a); wr_byte(8'h12, a);
    bus_rstart();
    k0 = txr_cnt;
    wr_byte(8'h91, a); check("R10 rstart read ack", 32'(a), 1);
    rd_byte(1'b0, b);  check("R10 rstart read data", 32'(b), 32'(pat(k0)));
    bus_stop();
    check("R11 drive changes only with scl low", 32'(oe_viol), 0);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_write();
    t_foreign();
    t_read();
    t_gcall();
    t_hs();
    t_rstart_mid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule